// File: doc/BRIEF.md
# Serial Configuration ROM Slave

This block models a 256-byte configuration memory that sits on a two-wire serial bus (I2C protocol) on a memory module. A host reads the module description over the bus. The host can also write to the upper half of the space. The lower 128 bytes belong to the module maker and are fixed at elaboration from parameters. Byte 63 is not stored. It is an integrity byte that the block computes as the low eight bits of the sum of bytes 0 to 62. The upper 128 bytes are user storage. The host can write them when the write-protect input is low.

The slave answers at 7-bit address `1010` followed by the three strap inputs, so eight modules can share one bus. It supports single-byte write, current-address read, random read through a repeated START, and sequential read. In a sequential read the word pointer advances after every byte and wraps from 255 to 0. SCL and SDA are sampled by the block's own clock through two-flop synchronisers. SDA is modelled as an open-drain pin: the line is pulled low while `sda_oe` is high, and `sda_o` is always 0.

Top module: `cfg_rom_i2c_slave`

## Requirements
- R1: After reset the slave does not drive SDA and the word pointer is 0.
- R2: An address byte whose upper seven bits equal `1010` followed by `strap[2:0]` is acknowledged, with bit 0 selecting read (1) or write (0). Any other address gets no acknowledge, and SDA stays released until the next START.
- R3: Byte 0 reads 0x80, byte 1 reads 0x08, byte 2 reads 0x04, byte 3 reads 0x0C, byte 4 reads 0x0A and byte 62 reads 0x12. All other bytes below 128 except 63 read the fill parameter (0x00 by default). Bytes 128 to 255 read 0xFF after reset.
- R4: Byte 63 reads as the low 8 bits of the sum of bytes 0 to 62.
- R5: A write frame is an address byte with write, then a word-address byte, then a data byte, each acknowledged. The data byte is stored at the word address when that address is 128 or above and write-protect is low.
- R6: A data byte aimed at addresses 0 to 127 is discarded. A data byte aimed at 128 to 255 while write-protect is high is also discarded. The data byte is still acknowledged, and the stored contents read back unchanged.
- R7: A read returns the byte at the word pointer, most significant bit first. The pointer can be set by a write frame cut short by a repeated START.
- R8: During a read the pointer advances after each byte and wraps from 255 to 0. The next byte is sent while the master acknowledges. A master not-acknowledge ends the read with SDA released.
- R9: SDA falling while SCL is high is a START. SDA rising while SCL is high is a STOP. A START at any point, even mid-byte, restarts address reception with the bit count cleared.
- R10: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_o | output | 1 | Value driven onto SDA, always 0 |
| sda_oe | output | 1 | High pulls SDA low |
| strap | input | 3 | Bus address select bits |
| wp | input | 1 | High blocks writes to the user half |

## Verification
The bench builds the block with its default presets, a fill value of 0x00 and erased user bytes of 0xFF. The expected checksum is therefore 0xB4, and the bench computes that value from its own model array. The full 8-bit word address makes the 255-to-0 wrap reachable in a four-byte sequential read. The bench changes the strap inputs during the run, so address matching is checked against two different strap values.

// File: rtl/cfg_rom_i2c_slave.sv
module cfg_rom_i2c_slave #(
  parameter int         DEPTH     = 256,
  parameter int         SUM_IDX   = 63,
  parameter int         REV_IDX   = 62,
  parameter logic [3:0] DEV_TYPE  = 4'b1010,
  parameter logic [7:0] USED_CNT  = 8'h80,
  parameter logic [7:0] SIZE_LOG  = 8'h08,
  parameter logic [7:0] MEM_KIND  = 8'h04,
  parameter logic [7:0] ROW_BITS  = 8'h0C,
  parameter logic [7:0] COL_BITS  = 8'h0A,
  parameter logic [7:0] REV_CODE  = 8'h12,
  parameter logic [7:0] LOW_FILL  = 8'h00,
  parameter logic [7:0] USER_INIT = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_o,
  output logic       sda_oe,
  input  logic [2:0] strap,
  input  logic       wp
);
  localparam int AW   = $clog2(DEPTH);
  localparam int HALF = DEPTH / 2;

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_WADDR, S_WDATA, S_ACK, S_RDATA, S_RACK} st_t;

  st_t          state, nxt;
  logic [1:0]   scl_m, sda_m;
  logic         scl_s, scl_q, sda_s, sda_q;
  logic [3:0]   cnt;
  logic [7:0]   sr, tx, csum, rd_byte;
  logic [AW-1:0] ptr;
  logic         mack;
  logic [7:0]   umem [HALF];
  logic [8*HALF-1:0] uflat;

  function automatic logic [7:0] fixed_byte(input int idx);
    case (idx)
      0:       return USED_CNT;
      1:       return SIZE_LOG;
      2:       return MEM_KIND;
      3:       return ROW_BITS;
      4:       return COL_BITS;
      REV_IDX: return REV_CODE;
      default: return LOW_FILL;
    endcase
  endfunction

  always_comb begin
    csum = '0;
    for (int i = 0; i < SUM_IDX; i++) csum = csum + fixed_byte(i);
  end

  always_comb begin
    if (ptr[AW-1])                 rd_byte = umem[ptr[AW-2:0]];
    else if (int'(ptr) == SUM_IDX) rd_byte = csum;
    else                           rd_byte = fixed_byte(int'(ptr));
  end

  always_comb
    for (int i = 0; i < HALF; i++) uflat[i*8 +: 8] = umem[i];

  wire rise    = scl_s & ~scl_q;
  wire fall    = ~scl_s & scl_q;
  wire start   = scl_s & scl_q & sda_q & ~sda_s;
  wire stop    = scl_s & scl_q & ~sda_q & sda_s;
  wire byte_in = fall && cnt == 4'd8;
  wire dev_hit = sr[7:1] == {DEV_TYPE, strap};
  wire wr_en   = state == S_WDATA && byte_in && ptr[AW-1] && !wp;

  assign sda_o  = 1'b0;
  assign sda_oe = (state == S_ACK) || (state == S_RDATA && !tx[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= '1; sda_m <= '1;
      scl_s <= 1'b1; scl_q <= 1'b1; sda_s <= 1'b1; sda_q <= 1'b1;
      state <= S_IDLE; nxt <= S_IDLE;
      cnt <= '0; sr <= '0; tx <= '1; ptr <= '0; mack <= 1'b0;
      for (int i = 0; i < HALF; i++) umem[i] <= USER_INIT;
    end else begin
      scl_m <= {scl_m[0], scl_i}; sda_m <= {sda_m[0], sda_i};
      scl_s <= scl_m[1]; sda_s <= sda_m[1];
      scl_q <= scl_s;    sda_q <= sda_s;
      if (start) begin
        state <= S_DEV; cnt <= '0;
      end else if (stop) begin
        state <= S_IDLE; cnt <= '0;
      end else if (rise) begin
        case (state)
          S_DEV, S_WADDR, S_WDATA: begin sr <= {sr[6:0], sda_s}; cnt <= cnt + 4'd1; end
          S_RDATA: cnt <= cnt + 4'd1;
          S_RACK:  mack <= !sda_s;
          default: ;
        endcase
      end else if (fall) begin
        case (state)
          S_DEV: if (byte_in) begin
            if (dev_hit) begin state <= S_ACK; nxt <= sr[0] ? S_RDATA : S_WADDR; end
            else state <= S_IDLE;
          end
          S_WADDR: if (byte_in) begin
            ptr <= sr[AW-1:0]; state <= S_ACK; nxt <= S_WDATA;
          end
          S_WDATA: if (byte_in) begin
            if (wr_en) umem[ptr[AW-2:0]] <= sr;
            ptr <= ptr + 1'b1; state <= S_ACK; nxt <= S_WDATA;
          end
          S_ACK: begin
            cnt <= '0; state <= nxt;
            if (nxt == S_RDATA) tx <= rd_byte;
          end
          S_RDATA: begin
            if (cnt == 4'd8) begin state <= S_RACK; ptr <= ptr + 1'b1; tx <= '1; end
            else tx <= {tx[6:0], 1'b1};
          end
          S_RACK: begin
            if (mack) begin tx <= rd_byte; cnt <= '0; state <= S_RDATA; end
            else state <= S_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  assert_drive_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && scl_q) |=> $stable(sda_oe));
  assert_foreign_nack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DEV && byte_in && !dev_hit) |=> (state == S_IDLE && !sda_oe));
  assert_protect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WDATA && byte_in && (!ptr[AW-1] || wp)) |=> $stable(uflat));
  assert_start_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (state == S_DEV && cnt == 4'd0 && !sda_oe));
  assert_ptr_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RDATA && fall && cnt == 4'd8 && ptr == '1) |=> ptr == '0);
  assert_read_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RACK && fall && !mack) |=> (state == S_IDLE && !sda_oe));
endmodule

// File: tb/tb_cfg_rom_i2c_slave.sv
module tb_cfg_rom_i2c_slave;
  localparam int Q = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic [2:0] strap = 3'b101;
  logic sda_o, sda_oe;
  wire  sda_line = sda_m & ~sda_oe;
  int checks = 0, failures = 0, cycles = 0;
  int model [256];
  int rq [$];
  logic scl_prev = 1'b1, oe_prev = 1'b0;

  always #4 clk = ~clk;

  cfg_rom_i2c_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_o(sda_o), .sda_oe(sda_oe), .strap(strap), .wp(wp));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      checks++;
      if (scl_prev && scl && sda_oe != oe_prev) begin
        failures++;
        $display("FAIL R10 actual=%0b expected=%0b", sda_oe, oe_prev);
      end
      if (sda_o !== 1'b0) begin
        failures++;
        $display("FAIL R10 sda_o actual=%0b expected=0", sda_o);
      end
    end
    scl_prev = scl; oe_prev = sda_oe;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic bit_out(input logic b);
    sda_m = b; wt(Q); scl = 1'b1; wt(2*Q); scl = 1'b0; wt(Q);
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q); b = sda_line; wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic start_c;
    sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic stop_c;
    sda_m = 1'b0; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b1; wt(2*Q);
  endtask

  task automatic send(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(a);
    ack = !a;
  endtask

  task automatic recv(input logic ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) bit_in(d[i]);
    bit_out(!ack);
  endtask

  function automatic logic [7:0] dev(input logic [2:0] s, input logic rd);
    return {4'b1010, s, rd};
  endfunction

  task automatic write_one(input int addr, input int data, output int acks);
    logic a;
    acks = 0;
    start_c;
    send(dev(strap, 1'b0), a); acks += int'(a);
    send(8'(addr), a);         acks += int'(a);
    send(8'(data), a);         acks += int'(a);
    stop_c;
  endtask

  task automatic read_from(input int addr, input int n, output int acks);
    logic a;
    logic [7:0] d;
    acks = 0;
    rq.delete();
    start_c;
    send(dev(strap, 1'b0), a); acks += int'(a);
    send(8'(addr), a);         acks += int'(a);
    start_c;
    send(dev(strap, 1'b1), a); acks += int'(a);
    for (int k = 0; k < n; k++) begin
      recv(k != n - 1, d);
      rq.push_back(int'(d));
    end
    stop_c;
  endtask

  initial begin
    int acks, sum;
    logic a;
    for (int i = 0; i < 256; i++) model[i] = (i < 128) ? 8'h00 : 8'hFF;
    model[0] = 8'h80; model[1] = 8'h08; model[2] = 8'h04;
    model[3] = 8'h0C; model[4] = 8'h0A; model[62] = 8'h12;
    sum = 0;
    for (int i = 0; i < 63; i++) sum += model[i];
    model[63] = sum & 8'hFF;

    wt(5); rst_n = 1'b1; wt(5);
    chk("R1 oe after reset", int'(sda_oe), 0);

    start_c; send(dev(3'b000, 1'b0), a); stop_c;
    chk("R2 foreign address nack", int'(a), 0);
    chk("R2 released after nack", int'(sda_oe), 0);

    read_from(0, 5, acks);
    chk("R2 R5 acks on read setup", acks, 3);
    for (int k = 0; k < 5; k++) chk("R3 R7 preset byte", rq[k], model[k]);

    read_from(62, 2, acks);
    chk("R3 revision byte", rq[0], 8'h12);
    chk("R4 checksum byte", rq[1], model[63]);

    write_one(130, 8'h5A, acks); model[130] = 8'h5A;
    chk("R5 write acks", acks, 3);
    read_from(130, 1, acks);
    chk("R5 readback", rq[0], model[130]);

    wp = 1'b1;
    write_one(140, 8'h33, acks);
    chk("R6 protected write still acked", acks, 3);
    wp = 1'b0;
    read_from(140, 1, acks);
    chk("R6 protected byte unchanged", rq[0], model[140]);

    write_one(10, 8'h77, acks);
    chk("R6 maker half write acked", acks, 3);
    read_from(10, 1, acks);
    chk("R6 maker half unchanged", rq[0], model[10]);
    read_from(63, 1, acks);
    chk("R4 checksum unchanged", rq[0], model[63]);

    write_one(254, 8'hA1, acks); model[254] = 8'hA1;
    write_one(255, 8'hB2, acks); model[255] = 8'hB2;
    read_from(254, 4, acks);
    chk("R8 seq 254", rq[0], model[254]);
    chk("R8 seq 255", rq[1], model[255]);
    chk("R8 wrap to 0", rq[2], model[0]);
    chk("R8 wrap to 1", rq[3], model[1]);
    chk("R8 released after nack", int'(sda_oe), 0);

    start_c; bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
    write_one(8'h81, 8'hC3, acks); model[8'h81] = 8'hC3;
    chk("R9 start mid-byte restarts", acks, 3);
    read_from(8'h81, 1, acks);
    chk("R9 data after restart", rq[0], model[8'h81]);

    strap = 3'b010;
    start_c; send(dev(3'b101, 1'b0), a); stop_c;
    chk("R2 old strap now nacked", int'(a), 0);
    read_from(1, 1, acks);
    chk("R2 new strap acked", acks, 3);
    chk("R7 read with new strap", rq[0], model[1]);

    wt(20);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule